// File: doc/BRIEF.md
# Multiplexed Bus Strobe Sequencer

This block drives the control pins of a 16-bit multiplexed address/data bus. A bus request names a read, a write or a DRAM refresh, together with the byte address bit and the transfer size. The block then steps through the bus states T1, T2, T3, any number of wait states (Tw) and T4. In each state it drives the address latch enable, the read and write strobes, the active-low high-byte enable and address bit 0. Every bus state lasts `CLKS_PER_STATE` clocks (default 2). This split lets the latch enable drop at the middle of T1 and lets the read strobe wait half a state after the bus is released.

On the first clock after reset is released, the block samples the level of the read pin, `rdSense`. An external pull-up holds that pin high. If the sample is low, the block enters queue-status mode until the next reset. In that mode the latch-enable pin and the write pin no longer carry strobes. Instead they show a two-bit code for instruction-queue events. The read strobe is held high, and bus cycles still sequence the high-byte enable and address bit 0.

Top module: `busStrobeGen`

## Requirements
- R1: `alePin` is high only during the first half of T1, which is the first clock of T1 by default. `a0Pin` does not change on the clock where `alePin` falls.
- R2: For a write (`reqKind`=1), `wrPinN` is low from the first clock of T2 through the end of T3 and every Tw. It returns high in T4.
- R3: For a read (`reqKind`=0) or a refresh (`reqKind`=2), `rdPinN` is low from the second half of T2 through the end of T3 and every Tw. It is never low in T1, and it returns high in T4.
- R4: The pair {`bhePinN`,`a0Pin`} during a bus cycle follows this encoding:
  - 00 is a word transfer (`reqWord`=1, `reqA0`=0).
  - 01 is the upper byte (`reqA0`=1).
  - 10 is the lower byte (`reqA0`=0, `reqWord`=0).
  - 11 is a refresh.
- R5: `bhePinN` holds its low level from T1 through T3 and every Tw, and is high in T4.
- R6: `ready` is sampled on the last clock of T3 and on the last clock of each Tw. Each low sample inserts one more Tw, which adds `CLKS_PER_STATE` clocks.
- R7: A request (`reqValid`=1) is taken only while the bus is idle. A request raised during a cycle has no effect on that cycle. An unstretched cycle lasts 4×`CLKS_PER_STATE` clocks, after which the bus is idle again.
- R8: While reset is asserted, and while idle in strobe mode, the pins read `alePin`=0, `rdPinN`=1, `wrPinN`=1, `bhePinN`=1 and `a0Pin`=0.
- R9: `rdSense` is sampled on the first clock edge after `rstN` rises. A low sample selects queue-status mode and a high sample selects strobe mode.
- R10: The mode chosen at reset holds until the next reset, whatever `rdSense` does afterwards.
- R11: In queue-status mode, {`wrPinN`,`alePin`} shows a queue code for exactly one clock, the clock after `qEvt` carries the event. `qEvt` 1 (first opcode byte) gives 01, 2 (subsequent byte) gives 11, and 3 (queue emptied) gives 10. At all other times the code is 00.
- R12: In queue-status mode, `rdPinN` stays high, and bus cycles still drive `bhePinN` and `a0Pin` as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Bus request, taken while idle |
| reqKind | input | 2 | 0 read, 1 write, 2 refresh |
| reqA0 | input | 1 | Byte address bit 0 |
| reqWord | input | 1 | 1 for a 16-bit transfer |
| ready | input | 1 | Synchronous ready, high ends the cycle |
| qEvt | input | 2 | Queue event: 0 none, 1 first byte, 2 next byte, 3 emptied |
| rdSense | input | 1 | Level on the read pin, sampled after reset |
| alePin | output | 1 | Address latch enable, or queue status bit 0 |
| rdPinN | output | 1 | Read strobe, active low |
| wrPinN | output | 1 | Write strobe (active low), or queue status bit 1 |
| bhePinN | output | 1 | High-byte enable, active low |
| a0Pin | output | 1 | Address bit 0, forced high for refresh |

## Verification
The bench compares every pin on every clock of each bus cycle against a scoreboard. Cycles cover all four byte-enable combinations and zero, one and two wait states, so an off-by-one in the ready sampling shows up as a strobe released too early or too late. A request raised in the middle of a read must leave the write strobe quiet. A design that latched it would corrupt the running cycle. The bench also drives `rdSense` the opposite way after the mode is taken, in both modes. A design that kept sampling would swap the latch-enable and write pins over to queue codes, or back. Each queue event is checked to last exactly one clock, to catch a code that sticks or arrives late.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4
  } busState_e;

  localparam logic [1:0] KIND_READ    = 2'd0;
  localparam logic [1:0] KIND_WRITE   = 2'd1;
  localparam logic [1:0] KIND_REFRESH = 2'd2;

  // control -> datapath strobes
  typedef struct packed {
    logic load;    // request accepted this clock
    logic active;  // any of T1..T4
    logic aleOn;   // first half of T1
    logic bheWin;  // T1..T3 and Tw
    logic wrWin;   // T2..T3 and Tw
    logic rdWin;   // second half of T2, T3 and Tw
  } strobes_t;

  // queue event -> {qs1,qs0}
  function automatic logic [1:0] qsCode(input logic [1:0] evt);
    case (evt)
      2'd1:    qsCode = 2'b01;
      2'd2:    qsCode = 2'b11;
      2'd3:    qsCode = 2'b10;
      default: qsCode = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/bsg_ctrl.sv
module bsg_ctrl
  import bsg_pkg::*;
#(
  parameter int CLKS_PER_STATE = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     ready,
  output strobes_t strb
);

  localparam int PW   = (CLKS_PER_STATE > 1) ? $clog2(CLKS_PER_STATE) : 1;
  localparam int HALF = CLKS_PER_STATE / 2;
  localparam logic [PW-1:0] LAST_PH = PW'(CLKS_PER_STATE - 1);
  localparam logic [PW-1:0] HALF_PH = PW'(HALF);

  busState_e stateQ, stateD;
  logic [PW-1:0] phaseQ;
  logic lastPh, firstHalf;

  assign lastPh    = (phaseQ == LAST_PH);
  assign firstHalf = (phaseQ < HALF_PH);

  always_comb begin
    case (stateQ)
      ST_T1:   stateD = ST_T2;
      ST_T2:   stateD = ST_T3;
      ST_T3:   stateD = ready ? ST_T4 : ST_TW;
      ST_TW:   stateD = ready ? ST_T4 : ST_TW;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
    end else if (stateQ == ST_IDLE) begin
      phaseQ <= '0;
      if (reqValid) stateQ <= ST_T1;
    end else if (lastPh) begin
      phaseQ <= '0;
      stateQ <= stateD;
    end else begin
      phaseQ <= phaseQ + PW'(1);
    end
  end

  always_comb begin
    strb.load   = (stateQ == ST_IDLE) && reqValid;
    strb.active = (stateQ != ST_IDLE);
    strb.aleOn  = (stateQ == ST_T1) && firstHalf;
    strb.bheWin = (stateQ == ST_T1) || (stateQ == ST_T2) ||
                  (stateQ == ST_T3) || (stateQ == ST_TW);
    strb.wrWin  = (stateQ == ST_T2) || (stateQ == ST_T3) || (stateQ == ST_TW);
    strb.rdWin  = ((stateQ == ST_T2) && !firstHalf) ||
                  (stateQ == ST_T3) || (stateQ == ST_TW);
  end

  // R6: a low ready at the end of T3 leads into a wait state
  assert_wait_on_not_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T3 && lastPh && !ready) |=> (stateQ == ST_TW));

  // R7: the cycle closes after T4 and the bus returns to idle
  assert_t4_returns_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_T4 && lastPh) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/bsg_datapath.sv
module bsg_datapath
  import bsg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   strb,
  input  logic [1:0] reqKind,
  input  logic       reqA0,
  input  logic       reqWord,
  input  logic [1:0] qEvt,
  input  logic       rdSense,
  output logic       alePin,
  output logic       rdPinN,
  output logic       wrPinN,
  output logic       bhePinN,
  output logic       a0Pin
);

  logic [1:0] kindQ;
  logic a0Q, wordQ;
  logic sampledQ, modeQsQ;
  logic [1:0] qsQ;
  logic isWrite, isRefresh;
  logic busWrN, busRdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ    <= KIND_READ;
      a0Q      <= 1'b0;
      wordQ    <= 1'b0;
      sampledQ <= 1'b0;
      modeQsQ  <= 1'b0;
      qsQ      <= 2'b00;
    end else begin
      if (!sampledQ) begin
        sampledQ <= 1'b1;
        modeQsQ  <= !rdSense;
      end
      qsQ <= qsCode(qEvt);
      if (strb.load) begin
        kindQ <= reqKind;
        a0Q   <= reqA0;
        wordQ <= reqWord;
      end
    end
  end

  assign isWrite   = (kindQ == KIND_WRITE);
  assign isRefresh = (kindQ == KIND_REFRESH);

  assign busWrN = !(strb.wrWin && isWrite);
  assign busRdN = !(strb.rdWin && !isWrite);

  assign alePin  = modeQsQ ? qsQ[0] : strb.aleOn;
  assign wrPinN  = modeQsQ ? qsQ[1] : busWrN;
  assign rdPinN  = modeQsQ ? 1'b1   : busRdN;
  assign bhePinN = !(strb.bheWin && !isRefresh && (wordQ || a0Q));
  assign a0Pin   = strb.active && (isRefresh || a0Q);

  // R1: the address bit is steady where the latch enable falls
  assert_addr_stable_at_ale_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQsQ && $fell(alePin)) |-> $stable(a0Pin));

  // R3: read strobe only falls once the bus was already in its data phase
  assert_rd_after_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdPinN) |-> $past(strb.wrWin));

  // R10: once taken, the mode never changes
  assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    sampledQ |=> $stable(modeQsQ));

  // R11: no event on the previous clock means a 00 code on the pins
  assert_qs_idle_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    (modeQsQ && $past(qEvt) == 2'd0) |-> ({wrPinN, alePin} == 2'b00));

endmodule

// File: rtl/busStrobeGen.sv
module busStrobeGen
  import bsg_pkg::*;
#(
  parameter int CLKS_PER_STATE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqA0,
  input  logic       reqWord,
  input  logic       ready,
  input  logic [1:0] qEvt,
  input  logic       rdSense,
  output logic       alePin,
  output logic       rdPinN,
  output logic       wrPinN,
  output logic       bhePinN,
  output logic       a0Pin
);

  strobes_t strb;

  bsg_ctrl #(.CLKS_PER_STATE(CLKS_PER_STATE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .strb     (strb)
  );

  bsg_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqKind (reqKind),
    .reqA0   (reqA0),
    .reqWord (reqWord),
    .qEvt    (qEvt),
    .rdSense (rdSense),
    .alePin  (alePin),
    .rdPinN  (rdPinN),
    .wrPinN  (wrPinN),
    .bhePinN (bhePinN),
    .a0Pin   (a0Pin)
  );

endmodule

// File: tb/busStrobeGen_tb.sv
`timescale 1ns/1ps
module busStrobeGen_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic reqA0 = 1'b0;
  logic reqWord = 1'b0;
  logic ready = 1'b1;
  logic [1:0] qEvt = 2'd0;
  logic rdSense = 1'b1;
  logic alePin, rdPinN, wrPinN, bhePinN, a0Pin;

  int total = 0;
  int bad = 0;
  bit qsMode = 1'b0;

  typedef struct {
    logic [4:0] vec;  // {ale, rdN, wrN, bheN, a0}
    string tag;
  } expItem_t;
  expItem_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  busStrobeGen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqA0(reqA0), .reqWord(reqWord), .ready(ready), .qEvt(qEvt),
    .rdSense(rdSense), .alePin(alePin), .rdPinN(rdPinN), .wrPinN(wrPinN),
    .bhePinN(bhePinN), .a0Pin(a0Pin)
  );

  function automatic logic [4:0] pins();
    return {alePin, rdPinN, wrPinN, bhePinN, a0Pin};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: pins{ale,rd,wr,bhe,a0} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compare one expected vector per clock
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        check(pins() === it.vec, it.tag, pins(), it.vec);
      end
    end
  end

  // st: 1=T1 2=T2 3=T3 4=Tw 5=T4
  function automatic logic [4:0] model(input int st, input int ph, input logic [1:0] kind,
                                       input logic a0, input logic word);
    logic isW, isRef, ale, rdN, wrN, bheN, a0o;
    isW   = (kind == 2'd1);
    isRef = (kind == 2'd2);
    ale   = !qsMode && st == 1 && ph == 0;
    rdN   = qsMode ? 1'b1 : !(!isW && ((st == 2 && ph == 1) || st == 3 || st == 4));
    wrN   = qsMode ? 1'b0 : !(isW && (st == 2 || st == 3 || st == 4));
    bheN  = !(!isRef && (word || a0) && st != 5);
    a0o   = isRef || a0;
    return {ale, rdN, wrN, bheN, a0o};
  endfunction

  task automatic busCycle(input logic [1:0] kind, input logic a0, input logic word,
                          input int waits, input bit intrude, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqA0 = a0; reqWord = word;
    ready = (waits == 0);
    @(posedge clk);
    #1;
    for (int st = 1; st <= 5; st++) begin
      int reps;
      reps = (st == 4) ? waits : 1;
      for (int r = 0; r < reps; r++)
        for (int ph = 0; ph < 2; ph++) begin
          expItem_t it;
          it.vec = model(st, ph, kind, a0, word);
          it.tag = tag;
          sb.push_back(it);
        end
    end
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 1; i < 5 + 2 * waits; i++) begin
      @(negedge clk);
      if (intrude && i == 2) begin  // R7: request during T2 must be ignored
        reqValid = 1'b1; reqKind = 2'd1; reqA0 = 1'b1; reqWord = 1'b1;
      end
      if (intrude && i == 3) reqValid = 1'b0;
    end
    ready = 1'b1;
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idleCheck(input string tag);
    logic [4:0] e;
    e = qsMode ? 5'b0_1_0_1_0 : 5'b0_1_1_1_0;
    @(negedge clk);
    #1;
    check(pins() === e, tag, pins(), e);
  endtask

  task automatic doReset(input logic sense);
    @(negedge clk);
    rstN = 1'b0; rdSense = sense; qsMode = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(pins() === 5'b0_1_1_1_0, "R8 pins during reset", pins(), 5'b0_1_1_1_0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(pins() === 5'b0_1_1_1_0, "R8 pins before mode sample", pins(), 5'b0_1_1_1_0);
    qsMode = !sense;
    idleCheck(sense ? "R9 strobe mode idle" : "R9 queue mode idle");
  endtask

  task automatic qsEvent(input logic [1:0] evt, input logic [1:0] code, input string tag);
    @(negedge clk);
    qEvt = evt;
    @(negedge clk);
    qEvt = 2'd0;
    #1;
    check({wrPinN, alePin} === code, tag, pins(), {1'b0, 1'b1, code[1], 1'b1, 1'b0});
    @(negedge clk);
    #1;
    check({wrPinN, alePin} === 2'b00, {tag, " one clock"}, pins(), 5'b0_1_0_1_0);
  endtask

  initial begin
    doReset(1'b1);
    busCycle(2'd0, 1'b0, 1'b1, 0, 1'b0, "R1 R3 R4 word read");
    busCycle(2'd1, 1'b1, 1'b0, 2, 1'b0, "R2 R5 R6 upper-byte write 2 waits");
    busCycle(2'd0, 1'b0, 1'b0, 1, 1'b0, "R3 R4 R6 lower-byte read 1 wait");
    busCycle(2'd2, 1'b0, 1'b0, 0, 1'b0, "R4 refresh");
    busCycle(2'd0, 1'b1, 1'b0, 0, 1'b1, "R7 request during cycle ignored");
    idleCheck("R7 idle after cycle");
    rdSense = 1'b0;
    repeat (3) @(negedge clk);
    idleCheck("R10 strobe mode kept");
    busCycle(2'd1, 1'b0, 1'b1, 0, 1'b0, "R10 word write after sense change");

    doReset(1'b0);
    qsEvent(2'd1, 2'b01, "R11 first byte");
    qsEvent(2'd2, 2'b11, "R11 next byte");
    qsEvent(2'd3, 2'b10, "R11 emptied");
    busCycle(2'd0, 1'b1, 1'b0, 1, 1'b0, "R12 read in queue mode");
    busCycle(2'd2, 1'b0, 1'b1, 0, 1'b0, "R12 refresh in queue mode");
    rdSense = 1'b1;
    repeat (3) @(negedge clk);
    idleCheck("R10 queue mode kept");
    qsEvent(2'd2, 2'b11, "R10 R11 event after sense change");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule